// File: doc/BRIEF.md
# Eviction Spill Controller

This block sits beside the eviction path of a private second-level cache in a many-core chip. Each time a block leaves a cache, the controller decides whether that block is worth keeping on chip. If it should be kept, the controller sends it to a peer core's cache. If not, it drops the block, so that it leaves the chip. A block is kept only when no other on-chip copy exists and it has not already used its one allowed move. A block whose forward count says it was already moved is dropped. Reuse by a core restores the block's single chance.

A block that arrives through a spill carries a marker. Any eviction that its placement forces in the receiving cache is classified as drop-only, so replacements never chain from cache to cache. The peer that receives a spill is picked in rotation among all cores except the one evicting.

Only one spill request can be pending at a time. It is held at the output until the receiving side accepts it. While it is pending, the controller refuses new evictions through a ready signal. Data movement and the receiving cache's own victim selection are done elsewhere.

Top module: `evict_spill_ctl`

## Requirements
- R1: After reset, evict_ready is 1 and both spill_valid and drop_valid are 0.
- R2: An accepted eviction with evict_last_copy = 0 gives drop_valid = 1 with drop_addr equal to the evicted address in the next cycle, and no spill.
- R3: An accepted eviction with evict_last_copy = 1, evict_by_spill = 0 and an effective forward count below the limit of 1 gives, in the next cycle, spill_valid = 1. spill_addr equals the evicted address and spill_fwd_cnt equals the effective count plus one.
- R4: When evict_reused = 0 and evict_fwd_cnt is 1 or more, an accepted eviction is dropped even if it is the last copy.
- R5: When evict_reused = 1, the effective forward count is zero whatever evict_fwd_cnt holds. Such a last-copy eviction not caused by a spill is spilled with spill_fwd_cnt = 1.
- R6: An eviction with evict_by_spill = 1 is always dropped, never spilled, so spills cannot chain.
- R7: The spill target is the core that follows the previous spill target in the order 0, 1, ..., NCORES-1, 0, and the evicting core is skipped. Before any spill after reset, the previous target counts as core NCORES-1. The target never equals the evicting core.
- R8: A pending spill keeps spill_valid, spill_addr, spill_target and spill_fwd_cnt unchanged until a clock edge with spill_ready = 1, and clears after it. While a spill is pending, evict_ready is 0 and any eviction offered is not taken: it causes no drop and no spill.
- R9: Each accepted eviction gives exactly one outcome, either a spill or a one-cycle drop pulse, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | An eviction is offered |
| evict_ready | output | 1 | An eviction can be taken this cycle |
| evict_addr | input | ADDR_W | Block address of the evicted line |
| evict_core | input | CORE_W | Core whose cache evicts |
| evict_last_copy | input | 1 | No other on-chip copy exists |
| evict_by_spill | input | 1 | Eviction forced by placing a spilled block |
| evict_fwd_cnt | input | CNT_W | Forward count carried by the block |
| evict_reused | input | 1 | Block was hit since it was placed |
| spill_valid | output | 1 | Spill request pending |
| spill_ready | input | 1 | Target accepts the spill request |
| spill_addr | output | ADDR_W | Address of the block to spill |
| spill_target | output | CORE_W | Core that receives the block |
| spill_fwd_cnt | output | CNT_W | Forward count to store with the placed block |
| drop_valid | output | 1 | One-cycle drop indication |
| drop_addr | output | ADDR_W | Address of the dropped block |

## Verification
The bench sweeps every combination of evicting core, forward count, reuse flag, spill-caused flag and last-copy flag. This separates the three drop causes (a shared copy, a used-up chance, a forced eviction) from the reuse case that re-arms a spill. Because spills are interleaved with evictions from every core, the rotation is checked both when the rotating pointer lands on the evicting core and when it does not. Each spill is held for zero, one or two extra cycles while a refused eviction is offered. This shows that the request stays frozen and that the refused eviction leaves no trace.

// File: rtl/spc_pkg.sv
package spc_pkg;
    parameter int NCORES    = 4;
    parameter int ADDR_W    = 16;
    parameter int CNT_W     = 2;
    parameter int FWD_LIMIT = 1;

    localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1;

    typedef logic [CORE_W-1:0] core_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        VERDICT_IDLE  = 2'd0,
        VERDICT_DROP  = 2'd1,
        VERDICT_SPILL = 2'd2
    } verdict_e;

    typedef struct packed {
        addr_t addr;
        core_t src;
        logic  last_copy;
        logic  by_spill;
        cnt_t  fwd_cnt;
        logic  reused;
    } evict_t;

    typedef struct packed {
        addr_t addr;
        core_t target;
        core_t src;
        cnt_t  fwd_cnt;
    } spill_t;

    // next core in rotation order, wrapping at NCORES
    function automatic core_t core_after(input core_t c);
        if (int'(c) >= NCORES - 1)
            return '0;
        else
            return c + core_t'(1);
    endfunction

    // a hit since placement restores the block's chance
    function automatic cnt_t live_count(input evict_t e);
        return e.reused ? '0 : e.fwd_cnt;
    endfunction

    // saturating increment of the forward count
    function automatic cnt_t bump_count(input cnt_t c);
        return (c == {CNT_W{1'b1}}) ? c : c + cnt_t'(1);
    endfunction
endpackage

// File: rtl/spc_verdict.sv
module spc_verdict
    import spc_pkg::*;
(
    input  logic     ev_valid,
    input  evict_t   ev,
    output verdict_e verdict,
    output cnt_t     next_cnt
);
    cnt_t eff_cnt;
    logic chance_left;

    always_comb begin
        eff_cnt     = live_count(ev);
        chance_left = (int'(eff_cnt) < FWD_LIMIT);
        next_cnt    = bump_count(eff_cnt);
        if (!ev_valid)
            verdict = VERDICT_IDLE;
        else if ((NCORES > 1) && ev.last_copy && !ev.by_spill && chance_left)
            verdict = VERDICT_SPILL;
        else
            verdict = VERDICT_DROP;
    end
endmodule

// File: rtl/spc_target_rr.sv
module spc_target_rr
    import spc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  core_t src,
    input  logic  advance,
    output core_t target
);
    core_t last_q;
    core_t first_try;

    always_comb begin
        first_try = core_after(last_q);
        target    = (first_try == src) ? core_after(first_try) : first_try;
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= core_t'(NCORES - 1);
        else if (advance)
            last_q <= target;
    end

    // R7: the rotation pointer only moves when a spill is issued
    a_r7_pointer_holds: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(last_q));
endmodule

// File: rtl/evict_spill_ctl.sv
module evict_spill_ctl
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evict_valid,
    output logic              evict_ready,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [CORE_W-1:0] evict_core,
    input  logic              evict_last_copy,
    input  logic              evict_by_spill,
    input  logic [CNT_W-1:0]  evict_fwd_cnt,
    input  logic              evict_reused,
    output logic              spill_valid,
    input  logic              spill_ready,
    output logic [ADDR_W-1:0] spill_addr,
    output logic [CORE_W-1:0] spill_target,
    output logic [CNT_W-1:0]  spill_fwd_cnt,
    output logic              drop_valid,
    output logic [ADDR_W-1:0] drop_addr
);
    evict_t   ev;
    verdict_e verdict;
    cnt_t     next_cnt;
    core_t    rr_target;
    logic     accept;
    logic     issue;

    spill_t   pend_q;
    logic     pend_v;
    logic     drop_v;
    addr_t    drop_a;

    assign ev.addr      = evict_addr;
    assign ev.src       = evict_core;
    assign ev.last_copy = evict_last_copy;
    assign ev.by_spill  = evict_by_spill;
    assign ev.fwd_cnt   = evict_fwd_cnt;
    assign ev.reused    = evict_reused;

    assign evict_ready = !pend_v;
    assign accept      = evict_valid && !pend_v;
    assign issue       = (verdict == VERDICT_SPILL);

    spc_verdict u_verdict (
        .ev_valid (accept),
        .ev       (ev),
        .verdict  (verdict),
        .next_cnt (next_cnt)
    );

    spc_target_rr u_rr (
        .clk     (clk),
        .rst     (rst),
        .src     (evict_core),
        .advance (issue),
        .target  (rr_target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_q <= '0;
            drop_v <= 1'b0;
            drop_a <= '0;
        end else begin
            drop_v <= (verdict == VERDICT_DROP);
            if (verdict == VERDICT_DROP)
                drop_a <= evict_addr;
            if (pend_v && spill_ready)
                pend_v <= 1'b0;
            if (issue) begin
                pend_v         <= 1'b1;
                pend_q.addr    <= evict_addr;
                pend_q.target  <= rr_target;
                pend_q.src     <= evict_core;
                pend_q.fwd_cnt <= next_cnt;
            end
        end
    end

    assign spill_valid   = pend_v;
    assign spill_addr    = pend_q.addr;
    assign spill_target  = pend_q.target;
    assign spill_fwd_cnt = pend_q.fwd_cnt;
    assign drop_valid    = drop_v;
    assign drop_addr     = drop_a;

    // R9: exactly one outcome after each accepted eviction
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready) |=> (spill_valid != drop_valid));

    // R2: a block with other copies is dropped with its own address
    a_r2_shared_dropped: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && !evict_last_copy)
        |=> (drop_valid && drop_addr == $past(evict_addr)));

    // R6: a forced eviction never spills
    a_r6_no_chain: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && evict_by_spill) |=> !spill_valid);

    // R4: a used chance without reuse forbids a spill
    a_r4_limit_drops: assert property (@(posedge clk) disable iff (rst)
        (evict_valid && evict_ready && !evict_reused
         && int'(evict_fwd_cnt) >= FWD_LIMIT) |=> !spill_valid);

    // R8: pending request frozen until accepted, nothing else taken
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (spill_valid && !spill_ready)
        |=> (spill_valid && $stable(spill_addr) && $stable(spill_target)
             && $stable(spill_fwd_cnt) && !drop_valid));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (spill_valid && spill_ready) |=> (!spill_valid && !drop_valid));

    // R7: never send a block back to the core that evicted it
    a_r7_not_self: assert property (@(posedge clk) disable iff (rst)
        spill_valid |-> (NCORES < 2 || pend_q.target != pend_q.src));
endmodule

// File: tb/sim_evict_spill_ctl.sv
`timescale 1ns/1ps
module sim_evict_spill_ctl;
    import spc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              evict_valid;
    logic              evict_ready;
    logic [ADDR_W-1:0] evict_addr;
    logic [CORE_W-1:0] evict_core;
    logic              evict_last_copy;
    logic              evict_by_spill;
    logic [CNT_W-1:0]  evict_fwd_cnt;
    logic              evict_reused;
    logic              spill_valid;
    logic              spill_ready;
    logic [ADDR_W-1:0] spill_addr;
    logic [CORE_W-1:0] spill_target;
    logic [CNT_W-1:0]  spill_fwd_cnt;
    logic              drop_valid;
    logic [ADDR_W-1:0] drop_addr;

    always #2 clk = ~clk;

    evict_spill_ctl u0 (
        .clk(clk), .rst(rst),
        .evict_valid(evict_valid), .evict_ready(evict_ready),
        .evict_addr(evict_addr), .evict_core(evict_core),
        .evict_last_copy(evict_last_copy), .evict_by_spill(evict_by_spill),
        .evict_fwd_cnt(evict_fwd_cnt), .evict_reused(evict_reused),
        .spill_valid(spill_valid), .spill_ready(spill_ready),
        .spill_addr(spill_addr), .spill_target(spill_target),
        .spill_fwd_cnt(spill_fwd_cnt),
        .drop_valid(drop_valid), .drop_addr(drop_addr)
    );

    int total = 0;
    int bad = 0;
    int prev_target = NCORES - 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int core, input int cnt, input bit reused,
                            input bit bs, input bit last, input int idx);
        int  eff;
        bit  exp_spill;
        int  tgt;
        int  addr;
        string why;
        eff       = reused ? 0 : cnt;
        exp_spill = last && !bs && (eff < FWD_LIMIT) && (NCORES > 1);
        addr      = (16'h1000 + idx * 7) % (1 << ADDR_W);

        @(negedge clk);
        check(evict_ready == 1'b1, "R8 ready before offer", int'(evict_ready), 1);
        evict_valid     = 1'b1;
        evict_addr      = ADDR_W'(addr);
        evict_core      = CORE_W'(core);
        evict_fwd_cnt   = CNT_W'(cnt);
        evict_reused    = reused;
        evict_by_spill  = bs;
        evict_last_copy = last;
        @(negedge clk);
        evict_valid = 1'b0;

        if (exp_spill) begin
            tgt = (prev_target + 1) % NCORES;
            if (tgt == core) tgt = (tgt + 1) % NCORES;
            prev_target = tgt;
            check(spill_valid == 1'b1, "R3 spill raised", int'(spill_valid), 1);
            check(drop_valid == 1'b0, "R9 no drop with spill", int'(drop_valid), 0);
            check(int'(spill_addr) == addr, "R3 spill address", int'(spill_addr), addr);
            check(int'(spill_target) == tgt, "R7 rotation target", int'(spill_target), tgt);
            check(int'(spill_target) != core, "R7 not evicting core", int'(spill_target), core);
            if (reused && cnt >= FWD_LIMIT)
                check(int'(spill_fwd_cnt) == 1, "R5 reuse resets count", int'(spill_fwd_cnt), 1);
            else
                check(int'(spill_fwd_cnt) == eff + 1, "R3 forward count", int'(spill_fwd_cnt), eff + 1);
            for (int k = 0; k < idx % 3; k++) begin
                evict_valid     = 1'b1;
                evict_addr      = ADDR_W'(addr ^ 16'h00ff);
                evict_last_copy = 1'b0;
                evict_by_spill  = 1'b0;
                @(negedge clk);
                check(evict_ready == 1'b0, "R8 refuse while pending", int'(evict_ready), 0);
                check(spill_valid == 1'b1, "R8 request held", int'(spill_valid), 1);
                check(int'(spill_addr) == addr && int'(spill_target) == tgt,
                      "R8 request stable", int'(spill_addr), addr);
                check(drop_valid == 1'b0, "R8 refused eviction ignored", int'(drop_valid), 0);
            end
            spill_ready = 1'b1;
            @(negedge clk);
            spill_ready = 1'b0;
            evict_valid = 1'b0;
            check(spill_valid == 1'b0, "R8 cleared after accept", int'(spill_valid), 0);
            check(drop_valid == 1'b0, "R8 no drop from refused offer", int'(drop_valid), 0);
        end else begin
            if (bs)        why = "R6 forced eviction dropped";
            else if (!last) why = "R2 shared copy dropped";
            else           why = "R4 chance used, dropped";
            check(drop_valid == 1'b1, why, int'(drop_valid), 1);
            check(int'(drop_addr) == addr, "R2 drop address", int'(drop_addr), addr);
            check(spill_valid == 1'b0, "R9 no spill with drop", int'(spill_valid), 0);
            @(negedge clk);
            check(drop_valid == 1'b0, "R9 drop is one pulse", int'(drop_valid), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int idx;
        rst             = 1'b1;
        evict_valid     = 1'b0;
        evict_addr      = '0;
        evict_core      = '0;
        evict_last_copy = 1'b0;
        evict_by_spill  = 1'b0;
        evict_fwd_cnt   = '0;
        evict_reused    = 1'b0;
        spill_ready     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(evict_ready == 1'b1, "R1 ready after reset", int'(evict_ready), 1);
        check(spill_valid == 1'b0, "R1 no spill after reset", int'(spill_valid), 0);
        check(drop_valid == 1'b0, "R1 no drop after reset", int'(drop_valid), 0);

        idx = 0;
        for (int last = 1; last >= 0; last--)
            for (int bs = 0; bs < 2; bs++)
                for (int reused = 0; reused < 2; reused++)
                    for (int cnt = 0; cnt < (1 << CNT_W); cnt++)
                        for (int core = 0; core < NCORES; core++) begin
                            run_case(core, cnt, reused[0], bs[0], last[0], idx);
                            idx++;
                        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule